// File: doc/BRIEF.md
# Interleaved Memory Line-Fill Responder

This block stands in for the main-memory side of a cache refill path. A cache controller presents a line address. The responder then returns the four 32-bit words of that 16-byte line. Every count in the block is in cycles of a memory bus that runs slower than the processor. All internal timing is counted in that bus clock.

A build-time parameter selects one of three memory organisations, each with its own bus-cycle cost:

- **Sequential.** A one-word-wide memory reads and sends each word in turn.
- **Wide.** A four-word-wide memory reads the whole line in one access and sends it in one transfer.
- **Banked.** Four banks access in parallel, then send their words on consecutive cycles.

One-word writes load the backing storage. A busy flag tells the requester when a new line request will be taken.

Top module: `line_fill_responder`

## Requirements
- R1: After synchronous reset, `busy`, `rsp_valid` and `rsp_last` are low.
- R2: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. `busy` is high from the next cycle until the cycle after the final beat.
- R3: Number the cycle after the acceptance edge as cycle 1. In sequential mode (ORG=0), the beats come in cycles 17, 33, 49 and 65, so the line takes 65 cycles (1 address + 4×15 access + 4×1 transfer).
- R4: In wide mode (ORG=1), exactly one beat comes in cycle 17, with all four lanes enabled (1 + 15 + 1 = 17 cycles).
- R5: In banked mode (ORG=2), beats come in consecutive cycles 17 to 20, so the line takes 1 + 15 + 4 = 20 cycles.
- R6: Word i of a line is carried in lane i, which is `rsp_data[32*i+31:32*i]`, and `rsp_lanes[i]` marks it. In sequential and banked modes each beat carries one lane, in ascending word order. Lanes that are not enabled read as zero.
- R7: Returned words equal the last value written to that line and word through the write port.
- R8: A request presented while `busy` is high is ignored. The line in progress continues unchanged and no extra beats follow it.
- R9: A write presented while `busy` is high is ignored. Its data never appears in any later response.
- R10: `rsp_last` is high on the final beat of a line and on no other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Line request strobe |
| req_line | input | LINE_AW | Line address of the request |
| busy | output | 1 | High while a line is being served |
| wr_en | input | 1 | One-word write strobe, honoured only when idle |
| wr_line | input | LINE_AW | Line address of the write |
| wr_word | input | log2(WORDS) | Word index within the line |
| wr_data | input | DATA_W | Write data |
| rsp_valid | output | 1 | Data beat strobe |
| rsp_last | output | 1 | Final beat of the line |
| rsp_lanes | output | WORDS | Lane enables for this beat |
| rsp_data | output | WORDS*DATA_W | Line-wide data bus, word i in lane i |

## Verification
One bench drives the same stimulus into all three organisations side by side. Each cycle it compares beat position, lane pattern and data against a per-mode timing table.

- **Directed lines.** The first line, the last line and a repeated line confirm that address decoding reaches both ends of the storage.
- **Random lines with rewrites.** Randomly chosen lines, some rewritten just before being read, show that stored data follows the latest write.
- **Stray traffic while busy.** Inside every fill, the bench issues a stray request and a stray write aimed at the line being served. A wrongly taken request would show up as an early restart. A wrongly taken write would show up as changed data, because the bank is read after the write.

// File: rtl/lfr_pkg.sv
package lfr_pkg;

    // memory organisation selector
    localparam int ORG_SEQ    = 0;
    localparam int ORG_WIDE   = 1;
    localparam int ORG_BANKED = 2;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ACCESS,
        PH_XFER
    } phase_e;

    // total bus cycles from acceptance to final beat
    function automatic int line_latency(input int org, input int words,
                                        input int a_cyc, input int c_cyc,
                                        input int x_cyc);
        int t;
        case (org)
            ORG_SEQ:  t = a_cyc + words * (c_cyc + x_cyc);
            ORG_WIDE: t = a_cyc + c_cyc + x_cyc;
            default:  t = a_cyc + c_cyc + words * x_cyc;
        endcase
        return t;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lfr_bank.sv
module lfr_bank #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cap,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // access result held until the transfer phase
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (cap) begin
            q <= store[raddr];
        end
    end

endmodule

// File: rtl/lfr_sequencer.sv
module lfr_sequencer
    import lfr_pkg::*;
#(
    parameter int ORG      = ORG_BANKED,
    parameter int WORDS    = 4,
    parameter int ADDR_CYC = 1,
    parameter int ACC_CYC  = 15,
    parameter int XFER_CYC = 1,
    localparam int IDX_W   = $clog2(WORDS),
    localparam int CNT_W   = $clog2(max3(ADDR_CYC, ACC_CYC, XFER_CYC) + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             busy,
    output logic             cap_all,
    output logic             cap_one,
    output logic [IDX_W-1:0] widx,
    output logic             beat,
    output logic             beat_last
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    phase_e            ph;
    logic [CNT_W-1:0]  cnt;
    logic              cnt_done;
    logic              line_done;

    assign cnt_done  = (cnt == '0);
    assign line_done = (ORG == ORG_WIDE) || (widx == LAST_IDX);
    assign busy      = (ph != PH_IDLE);
    assign beat      = (ph == PH_XFER) && cnt_done;
    assign beat_last = beat && line_done;

    generate
        if (ORG == ORG_SEQ) begin : g_seq_cap
            assign cap_all = 1'b0;
            assign cap_one = (ph == PH_ACCESS) && cnt_done;
        end else begin : g_par_cap
            assign cap_all = (ph == PH_ACCESS) && cnt_done;
            assign cap_one = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            cnt  <= '0;
            widx <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (req_valid) begin
                        ph   <= PH_ADDR;
                        cnt  <= CNT_W'(ADDR_CYC - 1);
                        widx <= '0;
                    end
                end
                PH_ADDR: begin
                    if (cnt_done) begin
                        ph  <= PH_ACCESS;
                        cnt <= CNT_W'(ACC_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_ACCESS: begin
                    if (cnt_done) begin
                        ph  <= PH_XFER;
                        cnt <= CNT_W'(XFER_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_XFER: begin
                    if (!cnt_done) begin
                        cnt <= cnt - 1'b1;
                    end else if (line_done) begin
                        ph <= PH_IDLE;
                    end else if (ORG == ORG_SEQ) begin
                        ph   <= PH_ACCESS;
                        cnt  <= CNT_W'(ACC_CYC - 1);
                        widx <= widx + 1'b1;
                    end else begin
                        cnt  <= CNT_W'(XFER_CYC - 1);
                        widx <= widx + 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // R5
    banked_order_chk: assert property (@(posedge clk) disable iff (rst)
        (ORG == ORG_BANKED && XFER_CYC == 1 && beat && !beat_last)
            |=> (beat && widx == $past(widx) + 1'b1));

    // R6
    seq_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (ORG == ORG_SEQ && beat) |=> !beat);

endmodule

// File: rtl/line_fill_responder.sv
module line_fill_responder
    import lfr_pkg::*;
#(
    parameter int ORG      = ORG_BANKED,
    parameter int LINE_AW  = 5,
    parameter int DATA_W   = 32,
    parameter int WORDS    = 4,
    parameter int ADDR_CYC = 1,
    parameter int ACC_CYC  = 15,
    parameter int XFER_CYC = 1,
    localparam int IDX_W   = $clog2(WORDS),
    localparam int DEPTH   = 1 << LINE_AW,
    localparam int LINE_LAT = line_latency(ORG, WORDS, ADDR_CYC, ACC_CYC, XFER_CYC),
    localparam int LAT_W   = $clog2(LINE_LAT + 2)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [LINE_AW-1:0]      req_line,
    output logic                    busy,
    input  logic                    wr_en,
    input  logic [LINE_AW-1:0]      wr_line,
    input  logic [IDX_W-1:0]        wr_word,
    input  logic [DATA_W-1:0]       wr_data,
    output logic                    rsp_valid,
    output logic                    rsp_last,
    output logic [WORDS-1:0]        rsp_lanes,
    output logic [WORDS*DATA_W-1:0] rsp_data
);

    logic               accept;
    logic [LINE_AW-1:0] line_q;
    logic               cap_all;
    logic               cap_one;
    logic [IDX_W-1:0]   widx;
    logic               beat;
    logic               beat_last;
    logic [DATA_W-1:0]  bank_q [WORDS];

    assign accept = req_valid && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
        end else if (accept) begin
            line_q <= req_line;
        end
    end

    lfr_sequencer #(
        .ORG      (ORG),
        .WORDS    (WORDS),
        .ADDR_CYC (ADDR_CYC),
        .ACC_CYC  (ACC_CYC),
        .XFER_CYC (XFER_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .busy      (busy),
        .cap_all   (cap_all),
        .cap_one   (cap_one),
        .widx      (widx),
        .beat      (beat),
        .beat_last (beat_last)
    );

    generate
        for (genvar i = 0; i < WORDS; i++) begin : g_bank
            logic bank_we;
            logic bank_cap;

            assign bank_we  = wr_en && !busy && (wr_word == IDX_W'(i));
            assign bank_cap = cap_all || (cap_one && widx == IDX_W'(i));

            lfr_bank #(
                .DATA_W (DATA_W),
                .DEPTH  (DEPTH)
            ) u_bank (
                .clk   (clk),
                .rst   (rst),
                .we    (bank_we),
                .waddr (wr_line),
                .wdata (wr_data),
                .cap   (bank_cap),
                .raddr (line_q),
                .q     (bank_q[i])
            );

            if (ORG == ORG_WIDE) begin : g_all_lanes
                assign rsp_lanes[i] = beat;
            end else begin : g_one_lane
                assign rsp_lanes[i] = beat && (widx == IDX_W'(i));
            end

            assign rsp_data[i*DATA_W +: DATA_W] = rsp_lanes[i] ? bank_q[i] : '0;
        end
    endgenerate

    assign rsp_valid = beat;
    assign rsp_last  = beat_last;

    // latency watch: counts bus cycles since the acceptance edge
    logic [LAT_W-1:0] lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
        end else if (accept) begin
            lat_q <= LAT_W'(1);
        end else if (busy) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    // R3
    line_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_last |-> (lat_q == LAT_W'(LINE_LAT)));

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);

    // R10
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_last |=> !busy);

    // R8
    quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !rsp_valid);

    // R6
    lane_count_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($countones(rsp_lanes) == ((ORG == ORG_WIDE) ? WORDS : 1)));

    // R8
    line_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(line_q));

endmodule

// File: tb/line_fill_responder_test.sv
module line_fill_responder_test;

    localparam int LINE_AW = 5;
    localparam int DEPTH   = 1 << LINE_AW;
    localparam int DW      = 32;
    localparam int NW      = 4;
    localparam int NORG    = 3;
    localparam int SPAN    = 70;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic              req_valid = 1'b0;
    logic [LINE_AW-1:0] req_line = '0;
    logic              wr_en = 1'b0;
    logic [LINE_AW-1:0] wr_line = '0;
    logic [1:0]        wr_word = '0;
    logic [DW-1:0]     wr_data = '0;

    logic              busy_o  [NORG];
    logic              valid_o [NORG];
    logic              last_o  [NORG];
    logic [NW-1:0]     lanes_o [NORG];
    logic [NW*DW-1:0]  data_o  [NORG];

    generate
        for (genvar g = 0; g < NORG; g++) begin : g_org
            line_fill_responder #(.ORG(g), .LINE_AW(LINE_AW)) uut (
                .clk       (clk),
                .rst       (rst),
                .req_valid (req_valid),
                .req_line  (req_line),
                .busy      (busy_o[g]),
                .wr_en     (wr_en),
                .wr_line   (wr_line),
                .wr_word   (wr_word),
                .wr_data   (wr_data),
                .rsp_valid (valid_o[g]),
                .rsp_last  (last_o[g]),
                .rsp_lanes (lanes_o[g]),
                .rsp_data  (data_o[g])
            );
        end
    endgenerate

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [DEPTH][NW];

    task automatic chk(input bit ok, input string req, input logic [NW*DW-1:0] act,
                       input logic [NW*DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int total_cycles(input int org);
        case (org)
            0: return 65;
            1: return 17;
            default: return 20;
        endcase
    endfunction

    // expected lane enables in cycle c after acceptance
    function automatic logic [NW-1:0] exp_lanes(input int org, input int c);
        logic [NW-1:0] m;
        m = '0;
        case (org)
            0: for (int i = 0; i < NW; i++) if (c == 17 + 16 * i) m[i] = 1'b1;
            1: if (c == 17) m = '1;
            default: if (c >= 17 && c <= 20) m[c - 17] = 1'b1;
        endcase
        return m;
    endfunction

    function automatic logic [NW*DW-1:0] exp_data(input int line, input logic [NW-1:0] m);
        logic [NW*DW-1:0] d;
        d = '0;
        for (int i = 0; i < NW; i++) if (m[i]) d[i*DW +: DW] = model[line][i];
        return d;
    endfunction

    task automatic do_write(input int line, input int word, input logic [DW-1:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_line = LINE_AW'(line); wr_word = 2'(word); wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
        model[line][word] = val;
    endtask

    task automatic fetch_line(input int line, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_line  = LINE_AW'(line);
        for (int c = 1; c <= SPAN; c++) begin
            @(negedge clk);
            if (c == 1) req_valid = 1'b0;
            // stray request, R8
            if (c == 5) begin req_valid = 1'b1; req_line = LINE_AW'(line ^ 1); end
            if (c == 6) req_valid = 1'b0;
            // stray write to the line being served, R9
            if (c == 7) begin
                wr_en = 1'b1; wr_line = LINE_AW'(line); wr_word = 2'd3;
                wr_data = ~model[line][3];
            end
            if (c == 8) wr_en = 1'b0;
            for (int g = 0; g < NORG; g++) begin
                logic [NW-1:0] m;
                bit in_line;
                m = exp_lanes(g, c);
                in_line = (c <= total_cycles(g));
                chk(busy_o[g] == in_line, $sformatf("R2 busy org%0d c%0d %s", g, c, tag),
                    (NW*DW)'(busy_o[g]), (NW*DW)'(in_line));
                chk(valid_o[g] == (m != '0), $sformatf("R3/R4/R5 valid org%0d c%0d", g, c),
                    (NW*DW)'(valid_o[g]), (NW*DW)'(m != '0));
                chk(last_o[g] == (c == total_cycles(g)), $sformatf("R10 last org%0d c%0d", g, c),
                    (NW*DW)'(last_o[g]), (NW*DW)'(c == total_cycles(g)));
                if (m != '0 || valid_o[g]) begin
                    chk(lanes_o[g] == m, $sformatf("R6 lanes org%0d c%0d", g, c),
                        (NW*DW)'(lanes_o[g]), (NW*DW)'(m));
                    chk(data_o[g] == exp_data(line, m),
                        $sformatf("R7/R9 data org%0d c%0d line%0d", g, c, line),
                        data_o[g], exp_data(line, m));
                end
            end
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1
        for (int g = 0; g < NORG; g++) begin
            chk(busy_o[g] == 1'b0, "R1 busy in reset", (NW*DW)'(busy_o[g]), '0);
            chk(valid_o[g] == 1'b0, "R1 valid in reset", (NW*DW)'(valid_o[g]), '0);
            chk(last_o[g] == 1'b0, "R1 last in reset", (NW*DW)'(last_o[g]), '0);
        end
        rst = 1'b0;
        @(negedge clk);
        for (int g = 0; g < NORG; g++)
            chk(busy_o[g] == 1'b0, "R1 busy after reset", (NW*DW)'(busy_o[g]), '0);

        for (int l = 0; l < DEPTH; l++)
            for (int w = 0; w < NW; w++)
                do_write(l, w, $urandom);

        // directed corners: first line, last line, repeated line
        fetch_line(0, "first");
        fetch_line(DEPTH - 1, "last");
        fetch_line(DEPTH - 1, "repeat");

        // R7: rewrite a word, then read it back
        do_write(9, 2, 32'hA5A5_0F0F);
        fetch_line(9, "rewritten");

        for (int k = 0; k < 20; k++) begin
            int line;
            line = int'($urandom % DEPTH);
            if ($urandom % 2 == 1) do_write(line, int'($urandom % NW), $urandom);
            fetch_line(line, "random");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule